// File: doc/BRIEF.md
# Buffered UART receiver with address filtering

This block turns an asynchronous serial line into a stream of received words held in a small queue. It takes a strobe that runs at sixteen times the bit rate. On each strobe it samples the synchronised line. It decides each bit from a vote of three samples taken around the middle of the bit. A frame is one start bit, then 8 or 9 data bits sent least significant bit first, then an optional parity bit, then a stop bit. Each finished word is stored in a four-entry queue, together with a framing-error bit and a parity-error bit. Software reads the queue one word at a time through a read strobe.

Status outputs report three things: data waiting, a sticky overrun, and whether the receiver is between frames. An interrupt pulse can fire on every stored word, or only once the queue reaches a fill threshold. For 9-bit multidrop links, an address filter passes only words whose ninth bit is set. The sixteen-times strobe comes from outside the block.

Top module: `uart_rx_buffered`

## Requirements
- R1: Each bit level is decided by a majority vote of three consecutive 16x samples taken at phases 7, 8 and 9 of the bit. A disturbance lasting one sample period does not change the received value.
- R2: `cfg_mode` selects the frame format:
  - 00: 8 data bits, no parity.
  - 01: 8 data bits, even parity.
  - 10: 8 data bits, odd parity.
  - 11: 9 data bits, no parity.

  Data arrives least significant bit first. In 8-bit formats `rd_data[8]` reads 0.
- R3: In the parity formats, `rd_perr` is 1 for a stored word whose parity bit does not give the selected even or odd total, and 0 otherwise. In formats 00 and 11 it is always 0.
- R4: `rd_ferr` is 1 for a stored word whose stop bit was voted low.
- R5: A falling edge starts a frame only if the vote at the middle of the start bit is low. Otherwise the receiver returns to idle and stores nothing.
- R6: The queue keeps up to 4 words in arrival order. `rd_data`, `rd_ferr` and `rd_perr` show the oldest word. `data_avail` is 1 while the queue is not empty. A cycle with `rd_en` high removes the oldest word.
- R7: If a word completes while the queue holds 4 words, `ovr_flag` is set and the word is not stored. While `ovr_flag` is 1, no completed word enters the queue. The flag stays set until it is cleared.
- R8: Pulsing `ovr_clr` while `ovr_flag` is 1 clears the flag and empties the queue.
- R9: `irq_mode` controls when `irq_pulse` goes high for one cycle, always one cycle after a word is stored:
  - 00 or 01: after every stored word.
  - 10: only when the store leaves 3 or 4 words in the queue.
  - 11: only when the store leaves the queue full.
- R10: With format 11 and `addr_det_en` = 1, a word is stored only if its bit 8 is 1. With `addr_det_en` = 0, every 9-bit word is stored.
- R11: In the 8-bit formats, `addr_det_en` has no effect on which words are stored.
- R12: While `enable` is 0, the queue is emptied, `ovr_flag` and `data_avail` are 0, any frame in progress is abandoned, and `rx_idle` is 1.
- R13: `rx_idle` is 0 from the accepted falling edge of a frame until the stop-bit vote, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable; low empties and resets the block |
| tick16 | input | 1 | One-cycle strobe at 16 times the bit rate |
| rx_in | input | 1 | Serial input line, idle high |
| cfg_mode | input | 2 | Frame format select (R2) |
| addr_det_en | input | 1 | Address filter enable for 9-bit format |
| irq_mode | input | 2 | Interrupt threshold select (R9) |
| rd_en | input | 1 | Remove the oldest word from the queue |
| ovr_clr | input | 1 | Clear overrun and empty the queue |
| rd_data | output | 9 | Oldest queued word |
| rd_ferr | output | 1 | Framing error of the oldest word |
| rd_perr | output | 1 | Parity error of the oldest word |
| data_avail | output | 1 | Queue not empty |
| ovr_flag | output | 1 | Sticky overrun |
| rx_idle | output | 1 | Receiver between frames |
| irq_pulse | output | 1 | Receive interrupt pulse |

## Verification
The bench sends a fifth and then a sixth word into a full queue. A design that let a word slip in after the overrun, or that dropped the oldest word to make room, would show the wrong head or the wrong word count when the queue is drained. It injects one-sample glitches in the middle of data bits and short low pulses on an idle line. A receiver that sampled only once would corrupt the byte, and a receiver that trusted the falling edge alone would store a phantom word. It also counts interrupt pulses in each threshold mode, sends data words past the address filter in both 9-bit and 8-bit formats, and drops `enable` in the middle of a frame to make sure no partial word survives.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    RX_IDLE   = 3'd0,
    RX_START  = 3'd1,
    RX_DATA   = 3'd2,
    RX_PARITY = 3'd3,
    RX_STOP   = 3'd4
  } rx_state_t;

  localparam logic [1:0] FMT_8N = 2'b00;
  localparam logic [1:0] FMT_8E = 2'b01;
  localparam logic [1:0] FMT_8O = 2'b10;
  localparam logic [1:0] FMT_9N = 2'b11;

  typedef struct packed {
    logic       perr;
    logic       ferr;
    logic [8:0] data;
  } rx_word_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // 1 when the parity bit does not give the requested total
  function automatic logic parity_bad(input logic [7:0] d, input logic p, input logic odd);
    return (^d) ^ p ^ odd;
  endfunction

  function automatic logic irq_hit(input logic [1:0] mode, input int unsigned fill,
                                   input int unsigned depth);
    case (mode)
      2'b10:   return fill >= (3 * depth) / 4;
      2'b11:   return fill == depth;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rx_in,
  output logic line,
  output logic vote
);
  import uart_rx_pkg::*;

  logic       sync1;
  logic       sync2;
  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      hist  <= 2'b11;
    end else begin
      sync1 <= rx_in;
      sync2 <= sync1;
      if (tick) hist <= {hist[0], sync2};
    end
  end

  assign line = sync2;
  assign vote = maj3(hist[1], hist[0], sync2);

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick,
  input  logic       line,
  input  logic       vote,
  input  logic [1:0] cfg_mode,
  output logic       word_done,
  output logic [8:0] word_data,
  output logic       word_ferr,
  output logic       word_perr,
  output logic       idle
);
  import uart_rx_pkg::*;

  localparam int PHW = $clog2(OVS);
  localparam int MID = OVS / 2 + 1;

  rx_state_t      st;
  logic [PHW-1:0] ph;
  logic [3:0]     bcnt;
  logic [8:0]     shreg;
  logic           pbit;
  logic           ferr_q;
  logic           nine;
  logic           par_en;
  logic           par_odd;
  logic [3:0]     last_bit;

  assign nine     = (cfg_mode == FMT_9N);
  assign par_en   = (cfg_mode == FMT_8E) || (cfg_mode == FMT_8O);
  assign par_odd  = (cfg_mode == FMT_8O);
  assign last_bit = nine ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      ph        <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      pbit      <= 1'b0;
      ferr_q    <= 1'b0;
      word_done <= 1'b0;
    end else if (!enable) begin
      st        <= RX_IDLE;
      ph        <= '0;
      word_done <= 1'b0;
    end else begin
      word_done <= 1'b0;
      if (tick) begin
        if (st == RX_IDLE) begin
          if (!line) begin
            st <= RX_START;
            ph <= PHW'(1);
          end
        end else begin
          ph <= (ph == PHW'(OVS - 1)) ? '0 : ph + 1'b1;
          if (ph == PHW'(MID)) begin
            case (st)
              RX_START: begin
                if (!vote) begin
                  st   <= RX_DATA;
                  bcnt <= '0;
                end else begin
                  st <= RX_IDLE;
                end
              end
              RX_DATA: begin
                shreg <= {vote, shreg[8:1]};
                if (bcnt == last_bit) st <= par_en ? RX_PARITY : RX_STOP;
                else bcnt <= bcnt + 1'b1;
              end
              RX_PARITY: begin
                pbit <= vote;
                st   <= RX_STOP;
              end
              RX_STOP: begin
                ferr_q    <= !vote;
                word_done <= 1'b1;
                st        <= RX_IDLE;
              end
              default: st <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign word_data = nine ? shreg : {1'b0, shreg[8:1]};
  assign word_ferr = ferr_q;
  assign word_perr = par_en ? parity_bad(word_data[7:0], pbit, par_odd) : 1'b0;
  assign idle      = (st == RX_IDLE);

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr;
  logic [PW-1:0] rptr;
  logic          do_push;
  logic          do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (do_push && !flush && wptr == PW'(g)) mem[g] <= wdata;
    end
  end

  assign rdata = mem[rptr];

endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered #(
  parameter int DEPTH = 4,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       tick16,
  input  logic       rx_in,
  input  logic [1:0] cfg_mode,
  input  logic       addr_det_en,
  input  logic [1:0] irq_mode,
  input  logic       rd_en,
  input  logic       ovr_clr,
  output logic [8:0] rd_data,
  output logic       rd_ferr,
  output logic       rd_perr,
  output logic       data_avail,
  output logic       ovr_flag,
  output logic       rx_idle,
  output logic       irq_pulse
);
  import uart_rx_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam int WW = $bits(rx_word_t);

  logic          line_s;
  logic          vote_s;
  logic          evt_word_done;
  logic [8:0]    f_data;
  logic          f_ferr;
  logic          f_perr;
  logic          word_bit8;
  logic          addr_pass;
  logic          push_req;
  logic          evt_push;
  logic          evt_pop;
  logic          evt_ovr_set;
  logic          flush;
  logic          fifo_full;
  logic          fifo_empty;
  logic [CW-1:0] fifo_count;
  logic [CW:0]   fill_after;
  rx_word_t      in_word;
  rx_word_t      head_word;
  logic [WW-1:0] head_bits;

  uart_rx_sampler u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick16),
    .rx_in (rx_in),
    .line  (line_s),
    .vote  (vote_s)
  );

  uart_rx_framer #(.OVS(OVS)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick16),
    .line      (line_s),
    .vote      (vote_s),
    .cfg_mode  (cfg_mode),
    .word_done (evt_word_done),
    .word_data (f_data),
    .word_ferr (f_ferr),
    .word_perr (f_perr),
    .idle      (rx_idle)
  );

  assign word_bit8   = f_data[8];
  assign addr_pass   = !(addr_det_en && cfg_mode == FMT_9N) || word_bit8;
  assign push_req    = evt_word_done && addr_pass && !ovr_flag;
  assign evt_push    = push_req && !fifo_full;
  assign evt_ovr_set = push_req && fifo_full;
  assign evt_pop     = rd_en && !fifo_empty;
  assign flush       = !enable || (ovr_clr && ovr_flag);

  assign in_word = '{perr: f_perr, ferr: f_ferr, data: f_data};

  uart_rx_fifo #(.DEPTH(DEPTH), .W(WW)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (evt_push),
    .wdata (in_word),
    .pop   (evt_pop),
    .rdata (head_bits),
    .count (fifo_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  assign head_word  = rx_word_t'(head_bits);
  assign rd_data    = head_word.data;
  assign rd_ferr    = head_word.ferr;
  assign rd_perr    = head_word.perr;
  assign data_avail = !fifo_empty;
  assign fill_after = {1'b0, fifo_count} + (CW+1)'(1) - (CW+1)'(evt_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag  <= 1'b0;
      irq_pulse <= 1'b0;
    end else if (!enable) begin
      ovr_flag  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      if (ovr_clr)          ovr_flag <= 1'b0;
      else if (evt_ovr_set) ovr_flag <= 1'b1;
      irq_pulse <= evt_push && irq_hit(irq_mode, 32'(fill_after), 32'(DEPTH));
    end
  end

endmodule

// File: rtl/uart_rx_buffered_chk.sv
module uart_rx_buffered_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enable,
  input logic                       ovr_clr,
  input logic                       ovr_flag,
  input logic                       data_avail,
  input logic                       rx_idle,
  input logic                       irq_pulse,
  input logic [1:0]                 cfg_mode,
  input logic                       addr_det_en,
  input logic                       evt_push,
  input logic                       evt_ovr_set,
  input logic                       evt_word_done,
  input logic                       word_bit8,
  input logic                       fifo_full,
  input logic [$clog2(DEPTH+1)-1:0] fifo_count
);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= ($clog2(DEPTH+1))'(DEPTH));

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && enable && !ovr_clr |=> ovr_flag);

  a_r7_no_store_in_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |-> !evt_push);

  a_r7_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ovr_set |-> fifo_full);

  a_r8_clear_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag && ovr_clr && enable |=> fifo_count == '0 && !ovr_flag);

  a_r9_irq_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(evt_push));

  a_r10_addr_filter: assert property (@(posedge clk) disable iff (!rst_n)
    evt_push && cfg_mode == 2'b11 && addr_det_en |-> word_bit8);

  a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> fifo_count == '0 && !ovr_flag && !data_avail && rx_idle);

  a_r13_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    evt_word_done |-> rx_idle);

endmodule

bind uart_rx_buffered uart_rx_buffered_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_rx_buffered_bench.sv
module uart_rx_buffered_bench;

  localparam int BITCLK = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       tick16 = 1'b0;
  logic       rx_in = 1'b1;
  logic [1:0] cfg_mode = 2'b00;
  logic       addr_det_en = 1'b0;
  logic [1:0] irq_mode = 2'b00;
  logic       rd_en = 1'b0;
  logic       ovr_clr = 1'b0;
  logic [8:0] rd_data;
  logic       rd_ferr;
  logic       rd_perr;
  logic       data_avail;
  logic       ovr_flag;
  logic       rx_idle;
  logic       irq_pulse;

  int n_chk = 0;
  int n_fail = 0;
  int irq_cnt = 0;
  logic [1:0] tdiv = '0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv   <= tdiv + 1'b1;
    tick16 <= (tdiv == 2'd3);
  end

  always @(negedge clk) if (irq_pulse) irq_cnt++;

  uart_rx_buffered u_uart_rx_buffered (
    .clk, .rst_n, .enable, .tick16, .rx_in, .cfg_mode, .addr_det_en, .irq_mode,
    .rd_en, .ovr_clr, .rd_data, .rd_ferr, .rd_perr, .data_avail, .ovr_flag,
    .rx_idle, .irq_pulse
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_line(input logic v, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      rx_in = v;
    end
  endtask

  // glitch_bit: frame bit index (0 = start) that gets a one-sample inversion
  task automatic send_word(input logic [8:0] d, input bit bad_par, input bit bad_stop,
                           input int glitch_bit);
    logic bits [12];
    int   n = 0;
    logic p;
    bits[n++] = 1'b0;
    for (int i = 0; i < ((cfg_mode == 2'b11) ? 9 : 8); i++) bits[n++] = d[i];
    if (cfg_mode == 2'b01 || cfg_mode == 2'b10) begin
      p = ^d[7:0];
      if (cfg_mode == 2'b10) p = ~p;
      if (bad_par) p = ~p;
      bits[n++] = p;
    end
    bits[n++] = bad_stop ? 1'b0 : 1'b1;
    for (int i = 0; i < n; i++) begin
      if (i == glitch_bit) begin
        hold_line(bits[i], 30);
        hold_line(~bits[i], 4);
        hold_line(bits[i], 30);
      end else begin
        hold_line(bits[i], BITCLK);
      end
    end
    hold_line(1'b1, 2 * BITCLK);
  endtask

  task automatic send(input logic [8:0] d);
    send_word(d, 1'b0, 1'b0, -1);
  endtask

  task automatic pop_head(input string req, input logic [8:0] d, input logic fe,
                          input logic pe);
    check({req, " avail"}, 32'(data_avail), 1);
    check({req, " data"}, 32'(rd_data), 32'(d));
    check({req, " ferr"}, 32'(rd_ferr), 32'(fe));
    check({req, " perr"}, 32'(rd_perr), 32'(pe));
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic zero_irq();
    @(posedge clk);
    irq_cnt = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R12 reset avail", 32'(data_avail), 0);
    check("R12 reset ovr", 32'(ovr_flag), 0);
    check("R13 reset idle", 32'(rx_idle), 1);
    check("R9 reset irq", 32'(irq_pulse), 0);
  endtask

  task automatic t_formats();
    cfg_mode = 2'b00;
    send(9'h0A5);
    pop_head("R2 8N A5", 9'h0A5, 0, 0);
    send(9'h01E);
    pop_head("R2 8N 1E", 9'h01E, 0, 0);
    cfg_mode = 2'b11;
    send(9'h1C3);
    pop_head("R2 9-bit 1C3", 9'h1C3, 0, 0);
    cfg_mode = 2'b00;
  endtask

  task automatic t_parity();
    cfg_mode = 2'b01;
    send_word(9'h0B7, 1'b0, 1'b0, -1);
    pop_head("R3 even ok", 9'h0B7, 0, 0);
    send_word(9'h0B7, 1'b1, 1'b0, -1);
    pop_head("R3 even bad", 9'h0B7, 0, 1);
    cfg_mode = 2'b10;
    send_word(9'h042, 1'b0, 1'b0, -1);
    pop_head("R3 odd ok", 9'h042, 0, 0);
    send_word(9'h042, 1'b1, 1'b0, -1);
    pop_head("R3 odd bad", 9'h042, 0, 1);
    cfg_mode = 2'b00;
  endtask

  task automatic t_framing();
    send_word(9'h066, 1'b0, 1'b1, -1);
    pop_head("R4 stop low", 9'h066, 1, 0);
    check("R5 no phantom after low stop", 32'(data_avail), 0);
    send(9'h099);
    pop_head("R4 stop high", 9'h099, 0, 0);
  endtask

  task automatic t_false_start();
    hold_line(1'b0, 16);
    hold_line(1'b1, 12 * BITCLK);
    check("R5 short low pulse stores nothing", 32'(data_avail), 0);
    check("R5 back to idle", 32'(rx_idle), 1);
    send(9'h05A);
    pop_head("R5 next frame intact", 9'h05A, 0, 0);
  endtask

  task automatic t_majority();
    send_word(9'h0FF, 1'b0, 1'b0, 3);
    pop_head("R1 low glitch in one bit", 9'h0FF, 0, 0);
    send_word(9'h000, 1'b0, 1'b0, 5);
    pop_head("R1 high glitch in zero bit", 9'h000, 0, 0);
  endtask

  task automatic t_order();
    send(9'h011); send(9'h022); send(9'h033); send(9'h044);
    check("R7 no overrun at four", 32'(ovr_flag), 0);
    pop_head("R6 order 1", 9'h011, 0, 0);
    pop_head("R6 order 2", 9'h022, 0, 0);
    pop_head("R6 order 3", 9'h033, 0, 0);
    pop_head("R6 order 4", 9'h044, 0, 0);
    check("R6 empty after reads", 32'(data_avail), 0);
  endtask

  task automatic t_overrun();
    send(9'h0A1); send(9'h0A2); send(9'h0A3); send(9'h0A4);
    send(9'h0A5);
    check("R7 overrun on fifth", 32'(ovr_flag), 1);
    check("R7 head kept", 32'(rd_data), 32'h0A1);
    send(9'h0A6);
    check("R7 still overrun", 32'(ovr_flag), 1);
    pop_head("R7 drain 1", 9'h0A1, 0, 0);
    pop_head("R7 drain 2", 9'h0A2, 0, 0);
    pop_head("R7 drain 3", 9'h0A3, 0, 0);
    pop_head("R7 drain 4", 9'h0A4, 0, 0);
    check("R7 no word taken during overrun", 32'(data_avail), 0);
    check("R7 sticky after drain", 32'(ovr_flag), 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    check("R8 cleared", 32'(ovr_flag), 0);
  endtask

  task automatic t_clear_flush();
    send(9'h0B1); send(9'h0B2); send(9'h0B3); send(9'h0B4); send(9'h0B5);
    check("R8 overrun set", 32'(ovr_flag), 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    check("R8 flag clear", 32'(ovr_flag), 0);
    check("R8 queue flushed", 32'(data_avail), 0);
    send(9'h0C7);
    pop_head("R8 receive after clear", 9'h0C7, 0, 0);
  endtask

  task automatic t_irq();
    irq_mode = 2'b01;
    zero_irq();
    send(9'h001); send(9'h002);
    check("R9 mode 01 pulses", 32'(irq_cnt), 2);
    pop_head("R9 m01 a", 9'h001, 0, 0);
    pop_head("R9 m01 b", 9'h002, 0, 0);
    irq_mode = 2'b10;
    zero_irq();
    send(9'h003); send(9'h004);
    check("R9 mode 10 quiet below three", 32'(irq_cnt), 0);
    send(9'h005); send(9'h006);
    check("R9 mode 10 pulses", 32'(irq_cnt), 2);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
    end
    irq_mode = 2'b11;
    zero_irq();
    send(9'h007); send(9'h008); send(9'h009);
    check("R9 mode 11 quiet before full", 32'(irq_cnt), 0);
    send(9'h00A);
    check("R9 mode 11 pulse at full", 32'(irq_cnt), 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
    end
    check("R6 drained", 32'(data_avail), 0);
    irq_mode = 2'b00;
  endtask

  task automatic t_addr();
    cfg_mode = 2'b11;
    addr_det_en = 1'b1;
    send(9'h055);
    check("R10 data word filtered", 32'(data_avail), 0);
    send(9'h1A3);
    pop_head("R10 address word kept", 9'h1A3, 0, 0);
    addr_det_en = 1'b0;
    send(9'h055);
    pop_head("R10 filter off", 9'h055, 0, 0);
    cfg_mode = 2'b00;
    addr_det_en = 1'b1;
    send(9'h03C);
    pop_head("R11 no effect in 8-bit", 9'h03C, 0, 0);
    addr_det_en = 1'b0;
  endtask

  task automatic t_disable();
    send(9'h0D1); send(9'h0D2);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    check("R12 queue emptied", 32'(data_avail), 0);
    check("R12 idle", 32'(rx_idle), 1);
    @(negedge clk); enable = 1'b1;
    fork
      send(9'h0FF);
      begin
        hold_line_wait(300);
        enable = 1'b0;
        hold_line_wait(3);
        check("R12 frame abandoned", 32'(rx_idle), 1);
        enable = 1'b1;
      end
    join
    check("R12 no partial word", 32'(data_avail), 0);
    send(9'h0E4);
    pop_head("R12 works after re-enable", 9'h0E4, 0, 0);
  endtask

  task automatic hold_line_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_idle();
    fork
      send(9'h081);
      begin
        hold_line_wait(200);
        check("R13 busy mid-frame", 32'(rx_idle), 0);
      end
    join
    check("R13 idle after frame", 32'(rx_idle), 1);
    pop_head("R13 word", 9'h081, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    enable = 1'b1;
    hold_line(1'b1, 2 * BITCLK);
    t_formats();
    t_parity();
    t_framing();
    t_false_start();
    t_majority();
    t_order();
    t_overrun();
    t_clear_flush();
    t_irq();
    t_addr();
    t_disable();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule